// File: doc/BRIEF.md
# Scatter-Gather Transmit Descriptor Walker

This block is the memory-to-stream engine of a scatter-gather DMA. Software places a chain of descriptors in memory, points the walker at the first one and names the last one as the tail. The walker then fetches each descriptor over a single word-wide memory port. It streams the referenced buffer out as 32-bit beats on a data stream and, for descriptors that open a packet, first sends five sideband words on a separate control stream. It then marks the descriptor done in memory and follows the link to the next one.

The walk pauses in one of two ways. It goes idle after handling the tail descriptor, and it resumes from the following link when a new tail is written. It halts when it meets a descriptor that is already marked done or when a descriptor fetch fails. Completion and error events are single-cycle pulses for the surrounding register and interrupt logic.

Top module: `sg_tx_walker`

## Requirements
- R1: After reset, `halted_o` is 1, `idle_o` is 0, and no memory request or stream valid is asserted.
- R2: A descriptor fetch starts only while `run_i` is 1 and neither `halted_o` nor `idle_o` is set. A rising edge of `run_i` clears both flags. A pulse on `tail_we_i` clears `idle_o`. While the walker is halted, a tail write causes no memory request.
- R3: Descriptor layout, little-endian 32-bit words relative to the descriptor address: link low word at +0x00, buffer address low word at +0x08, control at +0x18, status at +0x1C, and five sideband words at +0x20 to +0x30. The upper halves of the 64-bit fields are ignored. Control bits 22:0 hold the byte length, bit 26 marks end of packet and bit 27 marks start of packet. Fetch order is status, control, link, buffer, then the sideband words in ascending order.
- R4: If status bit 31 is already set when a descriptor is fetched, the walker sets `halted_o` and stops, with no further read, no write and no stream output.
- R5: For a start-of-packet descriptor, the five sideband words go out on the control stream in address order before any data beat, with `ctl_tlast_o` set only on the fifth word.
- R6: The buffer leaves as ceil(length/4) beats read from ascending word addresses. `dat_tkeep_o` is 4'hF except on the final beat, where it is 4'h1, 4'h3 or 4'h7 for length mod 4 of 1, 2 or 3. `dat_tlast_o` is set on the final beat only for an end-of-packet descriptor. A zero length produces no beats.
- R7: A stream output that is valid while its ready is low holds its valid and its payload unchanged.
- R8: After the data, the walker writes 0x80000000 to status (+0x1C) and then moves to the descriptor at the link address.
- R9: `cmplt_o` pulses once for each end-of-packet descriptor, in the cycle after its status write is acknowledged.
- R10: After the status write of the descriptor whose address equals the tail, `idle_o` is set and the walk stops. A later tail write resumes the walk from that descriptor's link.
- R11: A failed descriptor fetch stops the walk and sets `halted_o`. Response code 2'b10 pulses `err_dec_o`; codes 2'b01 and 2'b11 pulse `err_slv_o`. Error codes on buffer reads are ignored.
- R12: `mem_req_o` stays high with address, write flag and write data unchanged until `mem_rsp_i` is seen. The access completes on the clock edge where both are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Run enable; its rising edge clears halted and idle |
| cur_we_i | input | 1 | Load the current descriptor pointer (taken only between descriptors) |
| cur_addr_i | input | AW | New current descriptor pointer |
| tail_we_i | input | 1 | Load the tail pointer and clear idle |
| tail_addr_i | input | AW | New tail descriptor address |
| halted_o | output | 1 | Walk halted |
| idle_o | output | 1 | Tail reached |
| cmplt_o | output | 1 | Pulse: end-of-packet descriptor finished |
| err_dec_o | output | 1 | Pulse: descriptor fetch decode error |
| err_slv_o | output | 1 | Pulse: descriptor fetch slave error |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | AW | Byte address, word aligned |
| mem_wdata_o | output | 32 | Write data |
| mem_rsp_i | input | 1 | Access complete |
| mem_rerr_i | input | 2 | Response code, 0 is success |
| mem_rdata_i | input | 32 | Read data |
| dat_tvalid_o | output | 1 | Data stream valid |
| dat_tready_i | input | 1 | Data stream ready |
| dat_tdata_o | output | 32 | Data stream payload, lowest byte in bits 7:0 |
| dat_tkeep_o | output | 4 | Valid byte lanes |
| dat_tlast_o | output | 1 | End of packet |
| ctl_tvalid_o | output | 1 | Control stream valid |
| ctl_tready_i | input | 1 | Control stream ready |
| ctl_tdata_o | output | 32 | Sideband word |
| ctl_tlast_o | output | 1 | Fifth sideband word |

## Verification
Every fetch address is compared against the model as soon as it is issued. A state machine that skips or reorders a field therefore fails on the very next memory request, not at the end of a packet. A wrong remaining-byte count first appears as a bad `dat_tkeep_o` or a misplaced `dat_tlast_o` on the final beat, or as an extra or missing buffer read one request later. A wrong current or tail pointer shows up as a status write to the wrong address, or as the walk running past the tail, within one descriptor. Stall patterns on both ready inputs check that payloads hold, while the model's count of sideband words seen catches a data beat that overtakes the control stream.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
  localparam int DATA_W     = 32;
  localparam int BEAT_BYTES = DATA_W / 8;
  localparam int KEEP_W     = BEAT_BYTES;
  localparam int LEN_W      = 23;
  localparam int APP_WORDS  = 5;
  localparam int IDX_W      = $clog2(APP_WORDS);

  // descriptor field offsets in bytes
  localparam int OFS_LINK = 0;
  localparam int OFS_BUF  = 8;
  localparam int OFS_CTRL = 24;
  localparam int OFS_STAT = 28;
  localparam int OFS_APP  = 32;

  localparam int EOP_BIT  = 26;
  localparam int SOP_BIT  = 27;
  localparam int DONE_BIT = 31;

  localparam logic [1:0] RSP_DECODE = 2'b10;

  typedef enum logic [3:0] {
    S_WAIT, S_RD_STAT, S_RD_CTRL, S_RD_LINK, S_RD_BUF,
    S_RD_APP, S_APP_OUT, S_RD_DATA, S_DATA_OUT, S_WR_STAT
  } walk_st_t;
endpackage

// File: rtl/sgw_len_track.sv
module sgw_len_track
  import sgw_pkg::*;
#(
  parameter int LW = LEN_W,
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [LW-1:0]     len_i,
  input  logic              take_i,
  output logic              rem_zero_o,
  output logic              final_o,
  output logic [KEEP_W-1:0] keep_o,
  output logic [AW-1:0]     ofs_o
);
  localparam logic [LW-1:0] STEP_L = LW'(BEAT_BYTES);
  localparam logic [AW-1:0] STEP_A = AW'(BEAT_BYTES);

  logic [LW-1:0] rem_q, rem_d;
  logic [AW-1:0] ofs_q, ofs_d;
  logic          en;

  always_comb begin
    for (int b = 0; b < KEEP_W; b++) keep_o[b] = (rem_q > LW'(b));
    final_o    = (rem_q <= STEP_L);
    rem_zero_o = (rem_q == '0);
    ofs_o      = ofs_q;
  end

  always_comb begin
    en    = load_i | take_i;
    rem_d = rem_q;
    ofs_d = ofs_q;
    if (load_i) begin
      rem_d = len_i;
      ofs_d = '0;
    end else if (take_i) begin
      rem_d = final_o ? '0 : rem_q - STEP_L;
      ofs_d = ofs_q + STEP_A;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      ofs_q <= '0;
    end else if (en) begin
      rem_q <= rem_d;
      ofs_q <= ofs_d;
    end
  end

  AST_TAKE_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |-> !rem_zero_o); // R6
endmodule

// File: rtl/sgw_hold.sv
module sgw_hold #(
  parameter int W = 33
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] din_i,
  input  logic         ready_i,
  output logic         valid_o,
  output logic [W-1:0] dout_o
);
  logic         valid_q, valid_d;
  logic [W-1:0] data_q;

  always_comb begin
    valid_d = valid_q;
    if (valid_q && ready_i) valid_d = 1'b0;
    if (load_i)             valid_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      data_q <= '0;
    else if (load_i) data_q <= din_i;
  end

  assign valid_o = valid_q;
  assign dout_o  = data_q;

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && !ready_i |=> valid_o && $stable(dout_o)); // R7
  AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> !valid_o); // R7
endmodule

// File: rtl/sg_tx_walker.sv
module sg_tx_walker
  import sgw_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              cur_we_i,
  input  logic [AW-1:0]     cur_addr_i,
  input  logic              tail_we_i,
  input  logic [AW-1:0]     tail_addr_i,
  output logic              halted_o,
  output logic              idle_o,
  output logic              cmplt_o,
  output logic              err_dec_o,
  output logic              err_slv_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_rsp_i,
  input  logic [1:0]        mem_rerr_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              dat_tvalid_o,
  input  logic              dat_tready_i,
  output logic [DATA_W-1:0] dat_tdata_o,
  output logic [KEEP_W-1:0] dat_tkeep_o,
  output logic              dat_tlast_o,
  output logic              ctl_tvalid_o,
  input  logic              ctl_tready_i,
  output logic [DATA_W-1:0] ctl_tdata_o,
  output logic              ctl_tlast_o
);
  localparam int               DAT_W     = 1 + KEEP_W + DATA_W;
  localparam int               CTL_W     = 1 + DATA_W;
  localparam logic [IDX_W-1:0] LAST_APP  = IDX_W'(APP_WORDS - 1);
  localparam logic [DATA_W-1:0] DONE_WORD = DATA_W'(1) << DONE_BIT;

  walk_st_t         st_q, st_d;
  logic [AW-1:0]    cur_q, cur_d, tail_q, tail_d, link_q, buf_q;
  logic             sop_q, eop_q;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             halted_q, halted_d, idle_q, idle_d, run_q;
  logic             cmplt_q, cmplt_d, edec_q, edec_d, eslv_q, eslv_d;
  logic             link_en, buf_en, flag_en;
  logic             len_load, len_take, ctl_load, dat_load;
  logic             rem_zero, fin_beat;
  logic [KEEP_W-1:0] keep_w;
  logic [AW-1:0]    ofs_w;
  logic             rsp_fire, rsp_bad, desc_rd, desc_err, go;
  logic [DAT_W-1:0] dat_din, dat_dout;
  logic [CTL_W-1:0] ctl_din, ctl_dout;

  // ---------------- memory port ----------------
  always_comb begin
    mem_req_o = (st_q != S_WAIT) && (st_q != S_APP_OUT) && (st_q != S_DATA_OUT);
    mem_we_o  = (st_q == S_WR_STAT);
    mem_wdata_o = DONE_WORD;
    case (st_q)
      S_RD_STAT, S_WR_STAT: mem_addr_o = cur_q + AW'(OFS_STAT);
      S_RD_CTRL:            mem_addr_o = cur_q + AW'(OFS_CTRL);
      S_RD_LINK:            mem_addr_o = cur_q + AW'(OFS_LINK);
      S_RD_BUF:             mem_addr_o = cur_q + AW'(OFS_BUF);
      S_RD_APP:             mem_addr_o = cur_q + AW'(OFS_APP) + AW'({idx_q, 2'b00});
      S_RD_DATA:            mem_addr_o = buf_q + ofs_w;
      default:              mem_addr_o = cur_q;
    endcase
  end

  assign rsp_fire = mem_req_o && mem_rsp_i;
  assign rsp_bad  = (mem_rerr_i != 2'b00);
  assign desc_rd  = (st_q == S_RD_STAT) || (st_q == S_RD_CTRL) || (st_q == S_RD_LINK) ||
                    (st_q == S_RD_BUF)  || (st_q == S_RD_APP);
  assign desc_err = rsp_fire && desc_rd && rsp_bad;
  assign go       = run_i && !halted_q && !idle_q;

  // ---------------- next state ----------------
  always_comb begin
    st_d = st_q;   cur_d = cur_q;   tail_d = tail_q;   idx_d = idx_q;
    halted_d = halted_q;  idle_d = idle_q;
    cmplt_d = 1'b0;  edec_d = 1'b0;  eslv_d = 1'b0;
    link_en = 1'b0;  buf_en = 1'b0;  flag_en = 1'b0;
    len_load = 1'b0; len_take = 1'b0; ctl_load = 1'b0; dat_load = 1'b0;

    if (run_i && !run_q) begin
      halted_d = 1'b0;
      idle_d   = 1'b0;
    end
    if (tail_we_i) tail_d = tail_addr_i;

    case (st_q)
      S_WAIT: begin
        if (cur_we_i) cur_d = cur_addr_i;
        if (go)       st_d  = S_RD_STAT;
      end
      S_RD_STAT: if (rsp_fire && !rsp_bad) begin
        if (mem_rdata_i[DONE_BIT]) begin
          halted_d = 1'b1;
          st_d     = S_WAIT;
        end else begin
          st_d = S_RD_CTRL;
        end
      end
      S_RD_CTRL: if (rsp_fire && !rsp_bad) begin
        flag_en  = 1'b1;
        len_load = 1'b1;
        st_d     = S_RD_LINK;
      end
      S_RD_LINK: if (rsp_fire && !rsp_bad) begin
        link_en = 1'b1;
        st_d    = S_RD_BUF;
      end
      S_RD_BUF: if (rsp_fire && !rsp_bad) begin
        buf_en = 1'b1;
        idx_d  = '0;
        st_d   = sop_q ? S_RD_APP : (rem_zero ? S_WR_STAT : S_RD_DATA);
      end
      S_RD_APP: if (rsp_fire && !rsp_bad) begin
        ctl_load = 1'b1;
        st_d     = S_APP_OUT;
      end
      S_APP_OUT: if (!ctl_tvalid_o) begin
        if (idx_q == LAST_APP) begin
          st_d = rem_zero ? S_WR_STAT : S_RD_DATA;
        end else begin
          idx_d = idx_q + 1'b1;
          st_d  = S_RD_APP;
        end
      end
      S_RD_DATA: if (rsp_fire) begin
        dat_load = 1'b1;
        len_take = 1'b1;
        st_d     = S_DATA_OUT;
      end
      S_DATA_OUT: if (!dat_tvalid_o) begin
        st_d = rem_zero ? S_WR_STAT : S_RD_DATA;
      end
      S_WR_STAT: if (rsp_fire) begin
        cmplt_d = eop_q;
        cur_d   = link_q;
        if (cur_q == tail_q) idle_d = 1'b1;
        st_d    = S_WAIT;
      end
      default: st_d = S_WAIT;
    endcase

    if (desc_err) begin
      halted_d = 1'b1;
      edec_d   = (mem_rerr_i == RSP_DECODE);
      eslv_d   = (mem_rerr_i != RSP_DECODE);
      st_d     = S_WAIT;
    end
    // a tail write landing with the tail write-back must not be lost
    if (tail_we_i) idle_d = 1'b0;
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= S_WAIT;
      cur_q    <= '0;
      tail_q   <= '0;
      idx_q    <= '0;
      halted_q <= 1'b1;
      idle_q   <= 1'b0;
      run_q    <= 1'b0;
      cmplt_q  <= 1'b0;
      edec_q   <= 1'b0;
      eslv_q   <= 1'b0;
    end else begin
      st_q     <= st_d;
      cur_q    <= cur_d;
      tail_q   <= tail_d;
      idx_q    <= idx_d;
      halted_q <= halted_d;
      idle_q   <= idle_d;
      run_q    <= run_i;
      cmplt_q  <= cmplt_d;
      edec_q   <= edec_d;
      eslv_q   <= eslv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_q <= '0;
      buf_q  <= '0;
      sop_q  <= 1'b0;
      eop_q  <= 1'b0;
    end else begin
      if (link_en) link_q <= AW'(mem_rdata_i);
      if (buf_en)  buf_q  <= AW'(mem_rdata_i);
      if (flag_en) begin
        sop_q <= mem_rdata_i[SOP_BIT];
        eop_q <= mem_rdata_i[EOP_BIT];
      end
    end
  end

  // ---------------- datapath ----------------
  sgw_len_track #(.LW(LEN_W), .AW(AW)) u_len (
    .clk(clk), .rst_n(rst_n),
    .load_i(len_load), .len_i(mem_rdata_i[LEN_W-1:0]), .take_i(len_take),
    .rem_zero_o(rem_zero), .final_o(fin_beat), .keep_o(keep_w), .ofs_o(ofs_w)
  );

  assign dat_din = {eop_q && fin_beat, keep_w, mem_rdata_i};
  assign ctl_din = {idx_q == LAST_APP, mem_rdata_i};

  sgw_hold #(.W(DAT_W)) u_dat (
    .clk(clk), .rst_n(rst_n), .load_i(dat_load), .din_i(dat_din),
    .ready_i(dat_tready_i), .valid_o(dat_tvalid_o), .dout_o(dat_dout)
  );

  sgw_hold #(.W(CTL_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .load_i(ctl_load), .din_i(ctl_din),
    .ready_i(ctl_tready_i), .valid_o(ctl_tvalid_o), .dout_o(ctl_dout)
  );

  assign {dat_tlast_o, dat_tkeep_o, dat_tdata_o} = dat_dout;
  assign {ctl_tlast_o, ctl_tdata_o}              = ctl_dout;
  assign halted_o  = halted_q;
  assign idle_o    = idle_q;
  assign cmplt_o   = cmplt_q;
  assign err_dec_o = edec_q;
  assign err_slv_o = eslv_q;

  // ---------------- assertions ----------------
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && !mem_rsp_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)); // R12
  AST_PAUSED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (halted_o || idle_o) |-> !mem_req_o); // R2
  AST_ERR_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    (err_dec_o || err_slv_o) |-> halted_o && !(err_dec_o && err_slv_o)); // R11
  AST_KEEP_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    dat_tvalid_o |-> (dat_tkeep_o == 4'h1 || dat_tkeep_o == 4'h3 ||
                      dat_tkeep_o == 4'h7 || dat_tkeep_o == 4'hF)); // R6
  AST_STREAMS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(dat_tvalid_o && ctl_tvalid_o)); // R5
endmodule

// File: tb/sim_sg_tx_walker.sv
module sim_sg_tx_walker;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        run, cur_we, tail_we;
  logic [31:0] cur_addr, tail_addr;
  logic        halted, idle, cmplt, edec, eslv;
  logic        mreq, mwe, rsp;
  logic [31:0] maddr, mwdata, rdata;
  logic [1:0]  rerr;
  logic        dvalid, dready, dlast, cvalid, cready, clast;
  logic [31:0] ddata, cdata;
  logic [3:0]  dkeep;

  always #4 clk = ~clk; // 125 MHz

  sg_tx_walker #(.AW(32)) u0 (
    .clk(clk), .rst_n(rst_n), .run_i(run), .cur_we_i(cur_we), .cur_addr_i(cur_addr),
    .tail_we_i(tail_we), .tail_addr_i(tail_addr), .halted_o(halted), .idle_o(idle),
    .cmplt_o(cmplt), .err_dec_o(edec), .err_slv_o(eslv), .mem_req_o(mreq), .mem_we_o(mwe),
    .mem_addr_o(maddr), .mem_wdata_o(mwdata), .mem_rsp_i(rsp), .mem_rerr_i(rerr),
    .mem_rdata_i(rdata), .dat_tvalid_o(dvalid), .dat_tready_i(dready), .dat_tdata_o(ddata),
    .dat_tkeep_o(dkeep), .dat_tlast_o(dlast), .ctl_tvalid_o(cvalid), .ctl_tready_i(cready),
    .ctl_tdata_o(cdata), .ctl_tlast_o(clast)
  );

  logic [31:0] mem [logic [31:0]];
  logic [31:0] q_rd[$];
  logic [31:0] q_wr[$];
  logic [36:0] q_dat[$];
  int          q_dreq[$];
  logic [32:0] q_ctl[$];
  int n_chk = 0, n_fail = 0;
  int exp_cmplt = 0, exp_dec = 0, exp_slv = 0, ctl_exp_total = 0;
  int obs_cmplt = 0, obs_dec = 0, obs_slv = 0, obs_req = 0, ctl_seen = 0;
  bit exp_halt, exp_idle, stall_en = 0;
  logic [31:0] mcur, mtail, err_addr = 32'hFFFF_FFF0;
  logic [1:0]  err_code = 2'b00;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rdm(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  // reference walk: fills the expectation queues from the memory image
  task automatic mrd(input logic [31:0] a, output logic [31:0] d, output bit bad);
    q_rd.push_back(a);
    d = rdm(a);
    bad = 1'b0;
    if (a == err_addr && err_code != 2'b00) begin
      bad = 1'b1;
      exp_halt = 1'b1;
      if (err_code == 2'b10) exp_dec++; else exp_slv++;
    end
  endtask

  task automatic model_walk();
    logic [31:0] st, ctl, lnk, bufa, d, prev;
    bit bad;
    int len;
    for (int it = 0; it < 16; it++) begin
      mrd(mcur + 28, st, bad);   if (bad) return;
      if (st[31]) begin exp_halt = 1'b1; return; end
      mrd(mcur + 24, ctl, bad);  if (bad) return;
      mrd(mcur + 0, lnk, bad);   if (bad) return;
      mrd(mcur + 8, bufa, bad);  if (bad) return;
      if (ctl[27]) begin
        for (int i = 0; i < 5; i++) begin
          mrd(mcur + 32 + 4 * i, d, bad); if (bad) return;
          q_ctl.push_back({i == 4, d});
          ctl_exp_total++;
        end
      end
      len = int'(ctl[22:0]);
      for (int o = 0; o < len; o += 4) begin
        int rem;
        logic [3:0] kp;
        q_rd.push_back(bufa + o);
        rem = len - o;
        kp  = (rem >= 4) ? 4'hF : 4'((1 << rem) - 1);
        q_dat.push_back({ctl[26] && rem <= 4, kp, rdm(bufa + o)});
        q_dreq.push_back(ctl_exp_total);
      end
      q_wr.push_back(mcur + 28);
      if (ctl[26]) exp_cmplt++;
      prev = mcur;
      mcur = lnk;
      if (prev == mtail) begin exp_idle = 1'b1; return; end
    end
  endtask

  task automatic put_desc(input logic [31:0] a, input logic [31:0] lnk, input logic [31:0] b,
                          input logic [31:0] ctl, input logic [31:0] st);
    mem[a] = lnk;  mem[a + 4] = 32'hFFFF_FFFF;
    mem[a + 8] = b; mem[a + 12] = 32'hFFFF_FFFF;
    mem[a + 24] = ctl; mem[a + 28] = st;
    for (int i = 0; i < 5; i++) mem[a + 32 + 4 * i] = {a[15:0], 16'hA000 + 16'(i)};
    for (int i = 0; i < 8; i++) mem[b + 4 * i] = {b[15:0] ^ 16'h5A5A, 16'(i * 3 + 1)};
  endtask

  // memory responder, stream sinks and event counters
  always @(negedge clk) begin
    if (!rst_n) begin
      rsp = 1'b0;
    end else begin
      lfsr   = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      dready = stall_en ? lfsr[0] : 1'b1;
      cready = stall_en ? lfsr[5] : 1'b1;
      if (cvalid && cready) begin
        ctl_seen++;
        if (q_ctl.size() == 0) chk(0, "R5", "unexpected sideband word", {clast, cdata}, 0);
        else begin
          logic [32:0] e;
          e = q_ctl.pop_front();
          chk({clast, cdata} == e, "R5", "sideband word", {clast, cdata}, e);
        end
      end
      if (dvalid && dready) begin
        if (q_dat.size() == 0) chk(0, "R6", "unexpected data beat", {dlast, dkeep, ddata}, 0);
        else begin
          logic [36:0] e;
          int need;
          e = q_dat.pop_front();
          need = q_dreq.pop_front();
          chk({dlast, dkeep, ddata} == e, "R6", "data beat", {dlast, dkeep, ddata}, e);
          chk(ctl_seen >= need, "R5", "sideband before data", ctl_seen, need);
        end
      end
      if (cmplt) obs_cmplt++;
      if (edec)  obs_dec++;
      if (eslv)  obs_slv++;
      if (rsp) begin
        rsp = 1'b0;
      end else if (mreq) begin
        obs_req++;
        rsp = 1'b1;
        rerr = 2'b00;
        if (mwe) begin
          if (q_wr.size() == 0) chk(0, "R8", "unexpected write", maddr, 0);
          else begin
            logic [31:0] e;
            e = q_wr.pop_front();
            chk(maddr == e, "R8", "status write address", maddr, e);
          end
          chk(mwdata == 32'h8000_0000, "R8", "status write data", mwdata, 32'h8000_0000);
          mem[maddr] = mwdata;
        end else begin
          if (q_rd.size() == 0) chk(0, "R3", "unexpected read", maddr, 0);
          else begin
            logic [31:0] e;
            e = q_rd.pop_front();
            chk(maddr == e, "R3", "read address", maddr, e);
          end
          rdata = rdm(maddr);
          if (maddr == err_addr) rerr = err_code;
        end
      end
    end
  end

  task automatic drain(input string req);
    int t = 0;
    while ((q_rd.size() + q_wr.size() + q_dat.size() + q_ctl.size()) != 0 && t < 5000) begin
      @(negedge clk);
      t++;
    end
    chk(t < 5000, req, "walk drained", t, 0);
    repeat (12) @(negedge clk);
  endtask

  task automatic flags(input string req);
    chk(halted == exp_halt, req, "halted", halted, exp_halt);
    chk(idle == exp_idle, req, "idle", idle, exp_idle);
    chk(obs_cmplt == exp_cmplt, "R9", "completion pulses", obs_cmplt, exp_cmplt);
    chk(obs_dec == exp_dec, "R11", "decode error pulses", obs_dec, exp_dec);
    chk(obs_slv == exp_slv, "R11", "slave error pulses", obs_slv, exp_slv);
  endtask

  task automatic set_cur(input logic [31:0] a);
    @(negedge clk); cur_addr = a; cur_we = 1'b1;
    @(negedge clk); cur_we = 1'b0;
  endtask

  task automatic set_tail(input logic [31:0] a);
    @(negedge clk); tail_addr = a; tail_we = 1'b1;
    @(negedge clk); tail_we = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "R1", "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int req0;
    rst_n = 1'b0; run = 1'b0; cur_we = 1'b0; tail_we = 1'b0;
    cur_addr = '0; tail_addr = '0; rsp = 1'b0; rerr = 2'b00; rdata = '0;
    dready = 1'b1; cready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(halted == 1'b1, "R1", "halted after reset", halted, 1);
    chk(idle == 1'b0, "R1", "idle after reset", idle, 0);
    chk(mreq == 1'b0 && dvalid == 1'b0 && cvalid == 1'b0, "R1", "quiet after reset",
        {mreq, dvalid, cvalid}, 0);

    // three-descriptor packet: SOF len 10, len 4, EOF len 7
    put_desc(32'h1000, 32'h1040, 32'h4000, 32'h0800_000A, 32'h0);
    put_desc(32'h1040, 32'h1080, 32'h4100, 32'h0000_0004, 32'h0);
    put_desc(32'h1080, 32'h10C0, 32'h4200, 32'h0400_0007, 32'h0);
    put_desc(32'h10C0, 32'h1100, 32'h4300, 32'h0C00_0000, 32'h0);
    put_desc(32'h1100, 32'h1140, 32'h4400, 32'h0C00_000D, 32'h0);
    put_desc(32'h1140, 32'h1180, 32'h4500, 32'h0800_0008, 32'h8000_0000);

    // R2: a tail write while halted and not running starts nothing
    set_cur(32'h1000);
    set_tail(32'h1080);
    repeat (20) @(negedge clk);
    chk(obs_req == 0, "R2", "no request while halted", obs_req, 0);

    mcur = 32'h1000; mtail = 32'h1080; exp_halt = 0; exp_idle = 0;
    model_walk();
    run = 1'b1;
    drain("R10");
    flags("R10");
    chk(mem[32'h1000 + 28] == 32'h8000_0000, "R8", "status written back", mem[32'h101C], 32'h8000_0000);

    // R10 resume from the link after a new tail; zero length and stalls (R7)
    stall_en = 1;
    mtail = 32'h1100; exp_idle = 0;
    model_walk();
    set_tail(32'h1100);
    drain("R7");
    flags("R10");

    // R4 already-complete descriptor halts the walk
    mtail = 32'h1140; exp_idle = 0;
    model_walk();
    set_tail(32'h1140);
    drain("R4");
    flags("R4");
    req0 = obs_req;
    set_tail(32'h1140);
    repeat (20) @(negedge clk);
    chk(obs_req == req0, "R2", "halted ignores tail write", obs_req, req0);
    chk(dvalid == 1'b0 && cvalid == 1'b0, "R4", "no stream output", {dvalid, cvalid}, 0);

    // R11 decode error on the buffer pointer fetch
    stall_en = 0;
    put_desc(32'h1200, 32'h1240, 32'h4600, 32'h0400_0004, 32'h0);
    run = 1'b0;
    set_cur(32'h1200);
    set_tail(32'h1200);
    err_addr = 32'h1208; err_code = 2'b10;
    mcur = 32'h1200; mtail = 32'h1200; exp_halt = 0; exp_idle = 0;
    model_walk();
    @(negedge clk); run = 1'b1;
    drain("R11");
    flags("R11");

    // R11 slave error on the control fetch
    put_desc(32'h1300, 32'h1340, 32'h4700, 32'h0400_0004, 32'h0);
    run = 1'b0;
    set_cur(32'h1300);
    set_tail(32'h1300);
    err_addr = 32'h1318; err_code = 2'b01;
    mcur = 32'h1300; mtail = 32'h1300; exp_halt = 0; exp_idle = 0;
    model_walk();
    @(negedge clk); run = 1'b1;
    drain("R11");
    flags("R11");

    // R2 a fresh run edge clears halted; EOF len 5 with no SOF
    put_desc(32'h1400, 32'h1440, 32'h4800, 32'h0400_0005, 32'h0);
    err_addr = 32'hFFFF_FFF0; err_code = 2'b00;
    run = 1'b0;
    set_cur(32'h1400);
    set_tail(32'h1400);
    mcur = 32'h1400; mtail = 32'h1400; exp_halt = 0; exp_idle = 0;
    model_walk();
    @(negedge clk); run = 1'b1;
    drain("R2");
    flags("R2");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule